// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause 22 MDIO master that sits behind a small word-addressed register bus. Host software sets the serial clock divider, writes a command word naming a PHY and one of its registers, and either gets a read going immediately or supplies write data that launches the write. While a transfer runs, the block drives the management clock, shifts the 64-bit frame out, and releases the data line when a PHY is due to answer.

On a read, the 16 bits returned by the PHY land in the low half of the data register. A status bit records whether the PHY failed to pull the second turnaround bit low. A busy flag covers the whole transfer. Register writes that arrive while busy is set are dropped. The data pin is split into an output value, an output enable and an input, so the pad ring can build the bidirectional buffer.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy and read-error read as 0, the divider reads as the default value (20), the management clock is low and the data pin is released (output enable 0).
- R2: Register select 0 is configuration/status: busy at bit 0, read-error at bit 1, the 9-bit divider at bits 15:7. A divider write below 5 is ignored and the old divider is kept; values of 5 or more are taken.
- R3: While busy, the management clock period is 2 × divider host clocks. While idle the clock stays low.
- R4: Register select 1 is the command: register address at bits 4:0, PHY address at bits 9:5, read flag at bit 15. It reads back as written. Writing it with the read flag set starts a read frame.
- R5: Register select 2 is data (bits 15:0). Writing it while the stored command has the read flag clear starts a write frame carrying that data. If the stored command has the read flag set, the data is only stored and no frame starts.
- R6: A frame is 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, turnaround (10 on writes), and 16 data bits, each field MSB first.
- R7: On a read, the master drives the first 46 bits and releases the pin for the turnaround and the 16 data bits. When the frame ends, the sampled data appears in data bits 15:0.
- R8: Read-error is set when the second turnaround bit of a read is sampled as 1. It is cleared when the next frame starts.
- R9: Busy reads as 1 in the cycle after a start and holds until the frame ends. Writes to any register while busy are ignored.
- R10: The data pin changes only at falling edges of the management clock and is sampled at its rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 config/status, 1 command, 2 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input from the pin |

## Verification
The bench runs write frames with different PHY addresses, register addresses and data values, and checks each captured bit together with the output enable. This separates field misplacement, wrong opcodes and a wrong turnaround. Read frames use distinct response words and both turnaround values. These tell apart a correct capture from shifted or reversed data, and a correct error flag from one that is stuck or never cleared. Measuring the clock period at the default divider and at the minimum divider exposes counting off by one. Writing the registers during a frame and writing data behind a read command checks that no frame starts when one must not.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int BUS_W      = 32;
    localparam int DIV_W      = 9;
    localparam int DIV_MIN    = 5;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_FIRST   = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int DATA_FIRST = TA_FIRST + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam int CFG_BUSY_BIT = 0;
    localparam int CFG_ERR_BIT  = 1;
    localparam int CFG_DIV_LSB  = 7;
    localparam int CMD_REG_LSB  = 0;
    localparam int CMD_PHY_LSB  = 5;
    localparam int CMD_RD_BIT   = 15;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_cmd(input logic [BUS_W-1:0] w);
        mdio_cmd_t c;
        c.rd    = w[CMD_RD_BIT];
        c.phy   = w[CMD_PHY_LSB +: ADDR_W];
        c.regad = w[CMD_REG_LSB +: ADDR_W];
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                          input logic [DATA_W-1:0] d);
        logic [1:0] op;
        op = c.rd ? 2'b10 : 2'b01;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, 2'b10, d};
    endfunction

endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             terminal;

    assign terminal = run && (cnt_q == div - 1'b1);
    assign rise     = terminal && !mdc_q;
    assign fall     = terminal && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < div)); // R3

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DEF_DIV = 20
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              rderr,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_result,
    output logic [DIV_W-1:0]  div,
    output mdio_cmd_t         frame_cmd,
    output logic [DATA_W-1:0] frame_data,
    output logic              start_rd,
    output logic              start_wr
);

    reg_sel_e          sel;
    logic [DIV_W-1:0]  div_q;
    mdio_cmd_t         cmd_q;
    mdio_cmd_t         bus_cmd;
    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  new_div;
    logic              take;
    logic              unused_hi;

    assign sel       = reg_sel_e'(bus_addr);
    assign new_div   = bus_wdata[CFG_DIV_LSB +: DIV_W];
    assign bus_cmd   = decode_cmd(bus_wdata);
    assign take      = bus_wr && !busy;
    assign unused_hi = ^bus_wdata[BUS_W-1:DATA_W];

    assign start_rd   = take && (sel == SEL_CMD) && bus_cmd.rd;
    assign start_wr   = take && (sel == SEL_DATA) && !cmd_q.rd;
    assign frame_cmd  = start_rd ? bus_cmd : cmd_q;
    assign frame_data = bus_wdata[DATA_W-1:0];
    assign div        = div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DEF_DIV);
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (done && cmd_q.rd) begin
                data_q <= rd_result;
            end
            if (take) begin
                case (sel)
                    SEL_CFG:  if (new_div >= DIV_W'(DIV_MIN)) div_q <= new_div;
                    SEL_CMD:  cmd_q  <= bus_cmd;
                    SEL_DATA: data_q <= bus_wdata[DATA_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CFG: begin
                bus_rdata[CFG_DIV_LSB +: DIV_W] = div_q;
                bus_rdata[CFG_ERR_BIT]          = rderr;
                bus_rdata[CFG_BUSY_BIT]         = busy;
            end
            SEL_CMD: begin
                bus_rdata[CMD_RD_BIT]               = cmd_q.rd;
                bus_rdata[CMD_PHY_LSB +: ADDR_W]    = cmd_q.phy;
                bus_rdata[CMD_REG_LSB +: ADDR_W]    = cmd_q.regad;
            end
            SEL_DATA: bus_rdata[DATA_W-1:0] = data_q;
            default:  ;
        endcase
    end

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (rst)
        div_q >= DIV_W'(DIV_MIN)); // R2

    AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q)); // R9

endmodule

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_rd,
    input  logic              start_wr,
    input  mdio_cmd_t         frame_cmd,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    output logic              busy,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              rderr,
    output logic              done,
    output logic [DATA_W-1:0] rd_result
);

    logic [FRAME_BITS-1:0] sr_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    logic                  rd_q;
    logic                  err_q;
    logic [DATA_W-1:0]     sh_q;
    logic                  last;

    assign last      = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign done      = busy_q && fall && last;
    assign busy      = busy_q;
    assign rderr     = err_q;
    assign rd_result = sh_q;
    assign mdio_out  = busy_q & sr_q[FRAME_BITS-1];
    assign mdio_oe   = busy_q && (!rd_q || (idx_q < IDX_W'(TA_FIRST)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            err_q  <= 1'b0;
            sh_q   <= '0;
        end else if (!busy_q) begin
            if (start_rd || start_wr) begin
                busy_q <= 1'b1;
                rd_q   <= start_rd;
                sr_q   <= build_frame(frame_cmd, frame_data);
                idx_q  <= '0;
                err_q  <= 1'b0;
            end
        end else begin
            if (rise && rd_q) begin
                if (idx_q == IDX_W'(TA_FIRST + 1)) begin
                    err_q <= mdio_in;
                end else if (idx_q >= IDX_W'(DATA_FIRST)) begin
                    sh_q <= {sh_q[DATA_W-2:0], mdio_in};
                end
            end
            if (fall) begin
                if (last) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sr_q  <= sr_q << 1;
                end
            end
        end
    end

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$stable(mdio_out)) |-> $past(fall)); // R10

    AST_IDX_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$stable(idx_q)) |-> $past(fall)); // R10

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |=> busy_q); // R9

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DEF_DIV = 20
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    logic              busy;
    logic              rderr;
    logic              done;
    logic [DATA_W-1:0] rd_result;
    logic [DIV_W-1:0]  div;
    mdio_cmd_t         frame_cmd;
    logic [DATA_W-1:0] frame_data;
    logic              start_rd;
    logic              start_wr;
    logic              rise;
    logic              fall;

    mdio_mgmt_regs #(.DEF_DIV(DEF_DIV)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .rderr      (rderr),
        .done       (done),
        .rd_result  (rd_result),
        .div        (div),
        .frame_cmd  (frame_cmd),
        .frame_data (frame_data),
        .start_rd   (start_rd),
        .start_wr   (start_wr)
    );

    mdio_mgmt_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_mgmt_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .frame_cmd  (frame_cmd),
        .frame_data (frame_data),
        .rise       (rise),
        .fall       (fall),
        .mdio_in    (mdio_in),
        .busy       (busy),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .rderr      (rderr),
        .done       (done),
        .rd_result  (rd_result)
    );

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R7

endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;

    int checks = 0;
    int errors = 0;

    int          fall_cnt = 0;
    int          rise_cnt = 0;
    logic        ta_drv   = 1'b0;
    logic [15:0] resp     = 16'h0;
    logic [63:0] cap;
    logic [63:0] cap_oe;
    longint      prev_rise = 0;
    longint      period    = 0;

    always #5 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    // PHY responder: drives during read turnaround and data, pull-up otherwise
    assign mdio_in = (fall_cnt == 47) ? ta_drv :
                     ((fall_cnt >= 48 && fall_cnt <= 63) ? resp[63 - fall_cnt] : 1'b1);

    always @(negedge mdc) fall_cnt = fall_cnt + 1;

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap[63 - rise_cnt]    = mdio_out;
            cap_oe[63 - rise_cnt] = mdio_oe;
        end
        rise_cnt  = rise_cnt + 1;
        period    = $time - prev_rise;
        prev_rise = $time;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(2'd0, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic arm_phy(input logic ta, input logic [15:0] r);
        ta_drv   = ta;
        resp     = r;
        fall_cnt = 0;
        rise_cnt = 0;
        cap      = '0;
        cap_oe   = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(2'd0, v);
        chk("R1 cfg after reset", 64'(v), 64'(20 << 7));
        chk("R1 mdc low", 64'(mdc), 64'd0);
        chk("R1 oe released", 64'(mdio_oe), 64'd0);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        bus_write(2'd0, 32'(3 << 7));
        bus_read(2'd0, v);
        chk("R2 divider 3 ignored", 64'(v[15:7]), 64'd20);
        bus_write(2'd0, 32'(5 << 7));
        bus_read(2'd0, v);
        chk("R2 divider 5 taken", 64'(v[15:7]), 64'd5);
        bus_write(2'd0, 32'(20 << 7));
        bus_read(2'd0, v);
        chk("R2 divider 20 taken", 64'(v[15:7]), 64'd20);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] d, input int div);
        logic [31:0] v;
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d};
        arm_phy(1'b0, 16'h0);
        bus_write(2'd1, {16'h0, 1'b0, 5'h0, phy, ra});
        bus_read(2'd1, v);
        chk("R4 command readback", 64'(v), 64'({6'h0, phy, ra}));
        bus_write(2'd2, {16'h0, d});
        bus_read(2'd0, v);
        chk("R9 busy after data write", 64'(v[0]), 64'd1);
        wait_idle();
        chk("R5 R6 write frame bits", cap, exp);
        chk("R6 write drives all bits", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 mdc period", 64'(period), 64'(2 * div * 10));
        chk("R3 mdc low when idle", 64'(mdc), 64'd0);
        chk("R10 rising edges per frame", 64'(rise_cnt), 64'd64);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] r, input logic ta, input int div);
        logic [31:0] v;
        logic [45:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra};
        arm_phy(ta, r);
        bus_write(2'd1, {16'h0, 1'b1, 5'h0, phy, ra});
        bus_read(2'd0, v);
        chk("R9 busy after read command", 64'(v[0]), 64'd1);
        chk("R8 error cleared at frame start", 64'(v[1]), 64'd0);
        wait_idle();
        chk("R4 R6 read header bits", 64'(cap[63:18]), 64'(exp));
        chk("R7 release pattern", cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
        bus_read(2'd2, v);
        chk("R7 read result", 64'(v), 64'(r));
        bus_read(2'd0, v);
        chk("R8 read error flag", 64'(v[1]), 64'(ta));
        chk("R3 mdc period", 64'(period), 64'(2 * div * 10));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'hC3A5};
        arm_phy(1'b0, 16'h0);
        bus_write(2'd1, {16'h0, 1'b0, 5'h0, 5'h0A, 5'h15});
        bus_write(2'd2, 32'h0000_C3A5);
        repeat (200) @(negedge clk);
        bus_write(2'd1, 32'h0000_8000 | 32'h0000_0063);
        bus_write(2'd2, 32'h0000_BEEF);
        bus_write(2'd0, 32'(7 << 7));
        wait_idle();
        chk("R9 frame unaffected by busy writes", cap, exp);
        bus_read(2'd1, v);
        chk("R9 command kept", 64'(v), 64'({6'h0, 5'h0A, 5'h15}));
        bus_read(2'd2, v);
        chk("R9 data kept", 64'(v), 64'h0000_C3A5);
        bus_read(2'd0, v);
        chk("R9 divider kept", 64'(v[15:7]), 64'd20);
        repeat (50) @(negedge clk);
        bus_read(2'd0, v);
        chk("R9 no extra frame", 64'(v[0]), 64'd0);
    endtask

    task automatic t_data_no_start();
        logic [31:0] v;
        bus_write(2'd2, 32'h0000_1234);
        bus_read(2'd0, v);
        chk("R5 no frame behind read command", 64'(v[0]), 64'd0);
        repeat (5) @(negedge clk);
        bus_read(2'd0, v);
        chk("R5 still idle", 64'(v[0]), 64'd0);
        chk("R5 mdc idle", 64'(mdc), 64'd0);
        bus_read(2'd2, v);
        chk("R5 data stored", 64'(v), 64'h0000_1234);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        bus_wr    = 1'b0;
        bus_addr  = 2'd0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_divider();
        t_write(5'h01, 5'h00, 16'hA5F0, 20);
        t_write(5'h1F, 5'h1E, 16'h0001, 20);
        t_read(5'h03, 5'h02, 16'h8C31, 1'b0, 20);
        t_read(5'h10, 5'h07, 16'h7FFE, 1'b1, 20);
        t_read(5'h10, 5'h07, 16'h1248, 1'b0, 20);
        t_data_no_start();
        bus_write(2'd0, 32'(5 << 7));
        t_read(5'h15, 5'h0A, 16'hFFFF, 1'b0, 5);
        t_write(5'h0C, 5'h13, 16'h5A3C, 5);
        bus_write(2'd0, 32'(20 << 7));
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule